// File: doc/BRIEF.md
# Absolute Jump Next-PC Unit

This unit consumes instruction bytes one at a time from a fetch stage. It works out the next program counter for the absolute-jump group of an 8-bit processor. Three forms are recognised:

- an unconditional jump carrying a 16-bit immediate target;
- eight conditional jumps whose flag test is picked by a 3-bit field inside the opcode;
- register jumps that move HL, IX or IY straight into the program counter.

A register jump takes the register value itself. It never reads memory at that address. The IX and IY forms are a one-byte prefix followed by the HL-form opcode.

The surrounding core supplies the current PC, the three 16-bit register values and the sign, zero, parity/overflow and carry flags. These are sampled in the cycle the final byte of an instruction is accepted. One cycle later the unit pulses `done` for one cycle. At the same time it presents the next PC, the instruction length in bytes and the cycle cost.

Bytes outside the group produce a one-cycle `unsup` pulse instead, with the PC left unchanged. So does a prefix followed by anything other than the register-jump opcode. The unit changes no flag, so it has no flag output.

Top module: `abs_jump_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `done` and `unsup` in the next cycle and discards any partly collected instruction, including a pending prefix or low immediate byte. The next accepted byte is decoded as a first byte.
- R2: First byte 0xC3, then a low byte and then a high byte, yields `done`=1 one cycle after the high byte is accepted. It also yields `pc_next`={high,low}, `instr_len`=3 and `cyc_count`=10.
- R3: A first byte with bits 7:6 = 11 and bits 2:0 = 010 is a conditional jump, with its condition field in bits 5:3. After the low and high bytes, `pc_next` is {high,low} when the condition holds and `pc_in`+3 (mod 2^16) otherwise. In both cases `instr_len`=3 and `cyc_count`=10.
- R4: Condition field values:
  - 0 is taken when Z=0, and 1 when Z=1;
  - 2 is taken when C=0, and 3 when C=1;
  - 4 is taken when P/V=0, and 5 when P/V=1;
  - 6 is taken when S=0, and 7 when S=1.
- R5: First byte 0xE9 yields `done` one cycle after acceptance, with `pc_next`=`hl_in`, `instr_len`=1 and `cyc_count`=4.
- R6: Byte 0xDD then 0xE9 yields `pc_next`=`ix_in`, and 0xFD then 0xE9 yields `pc_next`=`iy_in`. Both give `instr_len`=2 and `cyc_count`=8.
- R7: 0xDD or 0xFD followed by any byte other than 0xE9 raises `unsup` for one cycle with `pc_next`=`pc_in`, and no `done`. The following byte is decoded as a first byte.
- R8: Any other first byte raises `unsup` for one cycle with `pc_next`=`pc_in`.
- R9: Cycles with `in_valid`=0 neither advance nor disturb collection. `done` and `unsup` only rise in the cycle after a byte is accepted.
- R10: `done` and `unsup` are never high together. Each is a single-cycle pulse per completed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Instruction byte from fetch |
| pc_in | input | 16 | Address of the current instruction |
| hl_in | input | 16 | HL register value |
| ix_in | input | 16 | IX register value |
| iy_in | input | 16 | IY register value |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_pv | input | 1 | Parity/overflow flag |
| flag_c | input | 1 | Carry flag |
| done | output | 1 | One-cycle pulse: jump resolved |
| pc_next | output | 16 | Next program counter |
| instr_len | output | 2 | Instruction length in bytes |
| cyc_count | output | 4 | Instruction cycle cost |
| unsup | output | 1 | One-cycle pulse: byte sequence outside the group |

## Verification
A wrong collection state shows up at the first byte that does not fit it, one cycle after that byte is accepted:

- A lost prefix turns an IX or IY jump into an HL jump.
- A stale low byte corrupts the upper or lower half of an immediate target.
- A stuck state misreads the next opcode as data, so `done` goes missing or `unsup` fires.

A bad condition decode appears only as a `pc_next` of `pc_in`+3 where the target was expected, or the reverse. Each of the eight codes is therefore driven with its flag both set and clear. Reset and idle cycles are placed in the middle of instructions, so that state surviving where it should not is exposed on the very next completion.

// File: rtl/jp_pkg.sv
package jp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PFX  = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } jp_state_e;

    typedef enum logic [1:0] {
        K_IMM = 2'd0,
        K_HL  = 2'd1,
        K_IX  = 2'd2,
        K_IY  = 2'd3
    } jp_kind_e;

    localparam logic [7:0] OP_JP_IMM = 8'hC3;
    localparam logic [7:0] OP_JP_REG = 8'hE9;
    localparam logic [7:0] OP_PFX_X  = 8'hDD;
    localparam logic [7:0] OP_PFX_Y  = 8'hFD;

    localparam int LEN_IMM = 3;
    localparam int LEN_HL  = 1;
    localparam int LEN_IDX = 2;
    localparam int CYC_IMM = 10;
    localparam int CYC_HL  = 4;
    localparam int CYC_IDX = 8;

endpackage

// File: rtl/jp_cond_eval.sv
module jp_cond_eval (
    input  logic [2:0] ccc,
    input  logic       flag_s,
    input  logic       flag_z,
    input  logic       flag_pv,
    input  logic       flag_c,
    output logic       take
);
    logic [3:0] flag_vec;
    logic       picked;

    always_comb begin
        // ccc[2:1] selects the flag; ccc[0] selects the polarity that jumps
        flag_vec = {flag_s, flag_pv, flag_c, flag_z};
        picked   = flag_vec[ccc[2:1]];
        take     = (picked == ccc[0]);
    end
endmodule

// File: rtl/jp_target_sel.sv
module jp_target_sel
    import jp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  jp_kind_e          kind,
    input  logic              take,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] iy,
    input  logic [ADDR_W-1:0] imm,
    output logic [ADDR_W-1:0] tgt
);
    localparam logic [ADDR_W-1:0] STEP_IMM = ADDR_W'(LEN_IMM);

    always_comb begin
        unique case (kind)
            K_IMM:   tgt = take ? imm : pc + STEP_IMM;
            K_HL:    tgt = hl;
            K_IX:    tgt = ix;
            default: tgt = iy;
        endcase
    end
endmodule

// File: rtl/abs_jump_unit.sv
module abs_jump_unit
    import jp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 2,
    parameter int CYC_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic [2*BYTE_W-1:0] pc_in,
    input  logic [2*BYTE_W-1:0] hl_in,
    input  logic [2*BYTE_W-1:0] ix_in,
    input  logic [2*BYTE_W-1:0] iy_in,
    input  logic                flag_s,
    input  logic                flag_z,
    input  logic                flag_pv,
    input  logic                flag_c,
    output logic                done,
    output logic [2*BYTE_W-1:0] pc_next,
    output logic [LEN_W-1:0]    instr_len,
    output logic [CYC_W-1:0]    cyc_count,
    output logic                unsup
);
    localparam int ADDR_W = 2 * BYTE_W;

    typedef struct packed {
        jp_state_e          st;
        logic               cond;
        logic [2:0]         ccc;
        logic               use_iy;
        logic [BYTE_W-1:0]  lo;
        logic               done;
        logic               unsup;
        logic [ADDR_W-1:0]  pc;
        logic [LEN_W-1:0]   len;
        logic [CYC_W-1:0]   cyc;
    } jp_regs_t;

    jp_regs_t          r_d, r_q;
    jp_kind_e          kind_c;
    logic              cond_true;
    logic              take_c;
    logic [ADDR_W-1:0] tgt_c;
    logic              is_cond_op;

    // Which target source the current byte would complete
    always_comb begin
        unique case (r_q.st)
            ST_HI:   kind_c = K_IMM;
            ST_PFX:  kind_c = r_q.use_iy ? K_IY : K_IX;
            default: kind_c = K_HL;
        endcase
    end

    jp_cond_eval u_cond (
        .ccc     (r_q.ccc),
        .flag_s  (flag_s),
        .flag_z  (flag_z),
        .flag_pv (flag_pv),
        .flag_c  (flag_c),
        .take    (cond_true)
    );

    assign take_c = !r_q.cond || cond_true;

    jp_target_sel #(.ADDR_W(ADDR_W)) u_tgt (
        .kind (kind_c),
        .take (take_c),
        .pc   (pc_in),
        .hl   (hl_in),
        .ix   (ix_in),
        .iy   (iy_in),
        .imm  ({in_byte, r_q.lo}),
        .tgt  (tgt_c)
    );

    assign is_cond_op = (in_byte[7:6] == 2'b11) && (in_byte[2:0] == 3'b010);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.unsup = 1'b0;
        if (in_valid) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (in_byte == OP_JP_IMM) begin
                        r_d.st   = ST_LO;
                        r_d.cond = 1'b0;
                    end else if (is_cond_op) begin
                        r_d.st   = ST_LO;
                        r_d.cond = 1'b1;
                        r_d.ccc  = in_byte[5:3];
                    end else if (in_byte == OP_JP_REG) begin
                        r_d.done = 1'b1;
                        r_d.pc   = tgt_c;
                        r_d.len  = LEN_W'(LEN_HL);
                        r_d.cyc  = CYC_W'(CYC_HL);
                    end else if (in_byte == OP_PFX_X || in_byte == OP_PFX_Y) begin
                        r_d.st     = ST_PFX;
                        r_d.use_iy = (in_byte == OP_PFX_Y);
                    end else begin
                        r_d.unsup = 1'b1;
                        r_d.pc    = pc_in;
                    end
                end
                ST_PFX: begin
                    r_d.st = ST_IDLE;
                    if (in_byte == OP_JP_REG) begin
                        r_d.done = 1'b1;
                        r_d.pc   = tgt_c;
                        r_d.len  = LEN_W'(LEN_IDX);
                        r_d.cyc  = CYC_W'(CYC_IDX);
                    end else begin
                        r_d.unsup = 1'b1;
                        r_d.pc    = pc_in;
                    end
                end
                ST_LO: begin
                    r_d.lo = in_byte;
                    r_d.st = ST_HI;
                end
                default: begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pc   = tgt_c;
                    r_d.len  = LEN_W'(LEN_IMM);
                    r_d.cyc  = CYC_W'(CYC_IMM);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign done      = r_q.done;
    assign unsup     = r_q.unsup;
    assign pc_next   = r_q.pc;
    assign instr_len = r_q.len;
    assign cyc_count = r_q.cyc;

endmodule

// File: rtl/abs_jump_unit_chk.sv
module abs_jump_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] pc_in,
    input logic [ADDR_W-1:0] hl_in,
    input logic [ADDR_W-1:0] ix_in,
    input logic [ADDR_W-1:0] iy_in,
    input logic              done,
    input logic [ADDR_W-1:0] pc_next,
    input logic [LEN_W-1:0]  instr_len,
    input logic [CYC_W-1:0]  cyc_count,
    input logic              unsup
);
    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> (!done && !unsup));

    assert_imm_cost_R2: assert property (@(posedge clk) disable iff (rst)
        (done && instr_len == LEN_W'(3)) |-> cyc_count == CYC_W'(10));

    assert_hl_target_R5: assert property (@(posedge clk) disable iff (rst)
        (done && instr_len == LEN_W'(1)) |-> (pc_next == $past(hl_in) && cyc_count == CYC_W'(4)));

    assert_idx_target_R6: assert property (@(posedge clk) disable iff (rst)
        (done && instr_len == LEN_W'(2)) |->
            (cyc_count == CYC_W'(8) && (pc_next == $past(ix_in) || pc_next == $past(iy_in))));

    assert_unsup_pc_R7: assert property (@(posedge clk) disable iff (rst)
        unsup |-> pc_next == $past(pc_in));

    assert_strobe_src_R9: assert property (@(posedge clk) disable iff (rst)
        (done || unsup) |-> $past(in_valid));

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && unsup));

    assert_len_legal_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> instr_len != '0);
endmodule

bind abs_jump_unit abs_jump_unit_chk #(
    .ADDR_W (2*BYTE_W),
    .LEN_W  (LEN_W),
    .CYC_W  (CYC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pc_in     (pc_in),
    .hl_in     (hl_in),
    .ix_in     (ix_in),
    .iy_in     (iy_in),
    .done      (done),
    .pc_next   (pc_next),
    .instr_len (instr_len),
    .cyc_count (cyc_count),
    .unsup     (unsup)
);

// File: tb/abs_jump_unit_tb.sv
`timescale 1ns/1ps
module abs_jump_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic [15:0] pc_in, hl_in, ix_in, iy_in;
    logic        flag_s, flag_z, flag_pv, flag_c;
    logic        done, unsup;
    logic [15:0] pc_next;
    logic [1:0]  instr_len;
    logic [3:0]  cyc_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    abs_jump_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .pc_in(pc_in), .hl_in(hl_in), .ix_in(ix_in), .iy_in(iy_in),
        .flag_s(flag_s), .flag_z(flag_z), .flag_pv(flag_pv), .flag_c(flag_c),
        .done(done), .pc_next(pc_next), .instr_len(instr_len),
        .cyc_count(cyc_count), .unsup(unsup)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit cond_holds(logic [2:0] c);
        case (c)
            3'd0: return !flag_z;
            3'd1: return flag_z;
            3'd2: return !flag_c;
            3'd3: return flag_c;
            3'd4: return !flag_pv;
            3'd5: return flag_pv;
            3'd6: return !flag_s;
            default: return flag_s;
        endcase
    endfunction

    // Drive one byte; return at the negedge after it was accepted, then idle gap cycles.
    task automatic put(logic [7:0] b, int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = $urandom;
        for (int g = 0; g < gap; g++) begin
            chk("R9 idle no strobe", {30'd0, done, unsup}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic randomize_core();
        pc_in = $urandom; hl_in = $urandom; ix_in = $urandom; iy_in = $urandom;
        {flag_s, flag_z, flag_pv, flag_c} = 4'($urandom);
    endtask

    task automatic expect_done(string tag, logic [15:0] epc, int elen, int ecyc);
        chk({tag, " done"}, {31'd0, done}, 32'd1);
        chk({tag, " unsup"}, {31'd0, unsup}, 32'd0);
        chk({tag, " pc"}, {16'd0, pc_next}, {16'd0, epc});
        chk({tag, " len"}, {30'd0, instr_len}, 32'(elen));
        chk({tag, " cyc"}, {28'd0, cyc_count}, 32'(ecyc));
        @(negedge clk);
        chk("R10 done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic expect_unsup(string tag, logic [15:0] epc);
        chk({tag, " unsup"}, {31'd0, unsup}, 32'd1);
        chk({tag, " no done"}, {31'd0, done}, 32'd0);
        chk({tag, " pc"}, {16'd0, pc_next}, {16'd0, epc});
        @(negedge clk);
        chk("R10 unsup single pulse", {31'd0, unsup}, 32'd0);
    endtask

    task automatic run_imm(bit cond, logic [2:0] c, int gap);
        logic [15:0] t;
        logic [15:0] e;
        t = $urandom;
        put(cond ? {2'b11, c, 3'b010} : 8'hC3, gap);
        put(t[7:0], gap);
        put(t[15:8], 0);
        if (!cond) e = t;
        else e = cond_holds(c) ? t : pc_in + 16'd3;
        expect_done(cond ? "R3 R4 cond jump" : "R2 uncond jump", e, 3, 10);
    endtask

    task automatic run_reg(int which, int gap);
        if (which == 0) begin
            put(8'hE9, 0);
            expect_done("R5 hl jump", hl_in, 1, 4);
        end else begin
            put(which == 1 ? 8'hDD : 8'hFD, gap);
            put(8'hE9, 0);
            expect_done("R6 index jump", which == 1 ? ix_in : iy_in, 2, 8);
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
        randomize_core();
        repeat (3) @(negedge clk);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset unsup", {31'd0, unsup}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4: every condition code with all flags clear then all set
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 8; c++) begin
                randomize_core();
                {flag_s, flag_z, flag_pv, flag_c} = v[0] ? 4'hF : 4'h0;
                run_imm(1'b1, 3'(c), 0);
            end
        end

        // R4: wraparound of not-taken address
        randomize_core();
        pc_in = 16'hFFFE; flag_z = 1'b1;
        run_imm(1'b1, 3'd0, 0);

        // R7 / R8 directed
        randomize_core(); put(8'h00, 0); expect_unsup("R8 bad first byte", pc_in);
        randomize_core(); put(8'hC9, 0); expect_unsup("R8 near opcode", pc_in);
        randomize_core(); put(8'hDD, 1); put(8'h00, 0); expect_unsup("R7 dd bad", pc_in);
        randomize_core(); put(8'hFD, 0); put(8'hC3, 0); expect_unsup("R7 fd bad", pc_in);
        randomize_core(); put(8'hDD, 0); put(8'hDD, 0); expect_unsup("R7 dd dd", pc_in);
        randomize_core(); run_reg(0, 0);   // R7 decoder back in first-byte state

        // R1: reset discards a pending prefix
        randomize_core();
        put(8'hDD, 0);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset mid prefix", {30'd0, done, unsup}, 32'd0);
        put(8'hE9, 0);
        expect_done("R1 prefix cleared", hl_in, 1, 4);

        // R1: reset discards a pending low byte
        randomize_core();
        put(8'hC3, 0); put(8'h34, 0);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        put(8'hE9, 0);
        expect_done("R1 imm cleared", hl_in, 1, 4);

        // Random mix with idle gaps (R9)
        for (int i = 0; i < 400; i++) begin
            int k;
            int gap;
            randomize_core();
            k   = $urandom_range(0, 4);
            gap = $urandom_range(0, 2);
            case (k)
                0: run_imm(1'b0, 3'd0, gap);
                1: run_imm(1'b1, 3'($urandom), gap);
                2: run_reg(0, gap);
                3: run_reg(1, gap);
                default: run_reg(2, gap);
            endcase
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule